// File: doc/BRIEF.md
# Host Parallel Slave Port

This block lets an external host processor use the local device as a memory-mapped peripheral. The host sees eight word-wide locations. Six of them are data mailboxes shared with the local core. The other two are read-only status words that tell which mailboxes hold unread data. The host runs on its own timing. The block brings every host pin into the local clock domain through a flop chain and acts on a host access only when the strobe is released.

Three static mode pins set the host bus shape:
- Data path of 16 bits or 8 bits.
- Address on its own pins, or multiplexed on the data bus and captured by an address-latch enable.
- Separate read and write strobes, or one direction line plus one data strobe.

In 8-bit mode the host moves each 16-bit word as two byte accesses, low byte first. Only the second access takes effect.

The core side is a plain synchronous register port: one write strobe, one read strobe, and a read-data register that is valid one cycle after the read strobe. Each mailbox has two flags. The host-wrote flag marks data left by the host for the core. The core-wrote flag marks data left by the core for the host. Both flag vectors also appear on output pins.

Top module: `hip_port`

## Requirements
- R1: While `rst` is high and after it falls, all mailboxes, both flag vectors, `h_dout`, `h_doe` and `c_rdata` are zero.
- R2: A committed host write to mailbox i (0..5) stores the word and sets `h2c_flags[i]`. A core read of mailbox i returns that word and clears the flag.
- R3: A core write to mailbox i stores the word and sets `c2h_flags[i]`. A committed host read of mailbox i returns that word and clears the flag.
- R4: When `mode_mux` is 1, the host address is taken from `h_din[2:0]` at the falling edge of `h_ale`. Later accesses use that latched address, and `h_addr` is ignored.
- R5: When `mode_rw` is 1, an access is the release of `h_ds_n`. `h_rnw` = 1 makes it a read and 0 makes it a write. `h_rd_n` and `h_wr_n` are then unused.
- R6: When `mode_byte` is 1, a write uses `h_din[7:0]`. The first access is the low byte and leaves the mailbox and its flag unchanged. The second access is the high byte and commits the whole word and sets the flag.
- R7: When `mode_byte` is 1, a read places the low byte and then the high byte on `h_dout[7:0]`, with `h_dout[15:8]` zero. `c2h_flags` clears only after the high-byte read.
- R8: Address 6 reads `c2h_flags` and address 7 reads `h2c_flags`, both zero-extended in bits [5:0]. Host writes to addresses 6 and 7 change nothing.
- R9: A host write takes effect only after its strobe is released. While the strobe is still held, the mailbox and its flag are unchanged.
- R10: `h_doe` is 1 while a host read strobe is asserted, after synchronization, and 0 once the strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_byte | input | 1 | 1: 8-bit host data path |
| mode_mux | input | 1 | 1: address multiplexed on data bus |
| mode_rw | input | 1 | 1: direction line plus data strobe |
| h_ale | input | 1 | Host address-latch enable (mux mode) |
| h_addr | input | 3 | Host register address (separate mode) |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_rnw | input | 1 | Host direction, 1 = read |
| h_ds_n | input | 1 | Host data strobe, active low |
| h_din | input | 16 | Host data (and multiplexed address) in |
| h_dout | output | 16 | Host read data, registered |
| h_doe | output | 1 | Host data output enable, registered |
| c_we | input | 1 | Core write strobe |
| c_re | input | 1 | Core read strobe |
| c_addr | input | 3 | Core register address |
| c_wdata | input | 16 | Core write data |
| c_rdata | output | 16 | Core read data, valid one cycle after `c_re` |
| h2c_flags | output | 6 | Host-wrote flag per mailbox |
| c2h_flags | output | 6 | Core-wrote flag per mailbox |

## Verification
The checker watches the flag logic on every cycle. It confirms that a committed host write or a core write sets the matching flag on the next cycle. It confirms that neither flag vector moves without a committed event from the side that owns it. This covers the rule that a low-byte access never touches a flag. It also confirms that reset clears the flags and the output enable. The bench scenarios must show the rest:
- the stored values and byte ordering,
- address capture from the multiplexed bus,
- the direction-plus-strobe convention,
- the read-only status words,
- the mailbox staying unchanged while a write strobe is still held.

// File: rtl/hip_pkg.sv
package hip_pkg;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_N_DATA = 6;
  localparam int DEF_ADDR_W = 3;
  localparam int DEF_SYNC   = 2;

  // host control pins carried through one synchronizer
  typedef struct packed {
    logic rd_n;
    logic wr_n;
    logic rnw;
    logic ds_n;
    logic ale;
  } hctl_t;

  localparam hctl_t HCTL_IDLE = '{rd_n: 1'b1, wr_n: 1'b1, rnw: 1'b1, ds_n: 1'b1, ale: 1'b0};
endpackage

// File: rtl/hip_sync.sv
module hip_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hip_host_fe.sv
module hip_host_fe
  import hip_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int SYNC   = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_byte,
  input  logic              mode_mux,
  input  logic              mode_rw,
  input  hctl_t             ctl_raw,
  input  logic [ADDR_W-1:0] addr_raw,
  input  logic [DATA_W-1:0] din_raw,
  output logic              wr_ev,
  output logic              rd_ev,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] ev_data,
  output logic              phase_hi,
  output logic              rd_active
);
  localparam int BYTE_W = DATA_W / 2;

  hctl_t             s_ctl, p_ctl;
  logic [ADDR_W-1:0] s_addr, lat_addr;
  logic [DATA_W-1:0] s_din;
  logic [BYTE_W-1:0] lo_hold;

  hip_sync #(.W($bits(hctl_t)), .STAGES(SYNC), .RST_VAL(HCTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(s_ctl));
  hip_sync #(.W(ADDR_W), .STAGES(SYNC), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst(rst), .d(addr_raw), .q(s_addr));
  hip_sync #(.W(DATA_W), .STAGES(SYNC), .RST_VAL('0)) u_sync_din (
    .clk(clk), .rst(rst), .d(din_raw), .q(s_din));

  always_ff @(posedge clk) begin
    if (rst) p_ctl <= HCTL_IDLE;
    else     p_ctl <= s_ctl;
  end

  // trailing-edge detection of each active-low strobe
  logic rd_rel, wr_rel, ds_rel, acc_rd, acc_wr, commit;
  assign rd_rel = s_ctl.rd_n & ~p_ctl.rd_n;
  assign wr_rel = s_ctl.wr_n & ~p_ctl.wr_n;
  assign ds_rel = s_ctl.ds_n & ~p_ctl.ds_n;
  assign acc_rd = mode_rw ? (ds_rel & p_ctl.rnw)  : rd_rel;
  assign acc_wr = mode_rw ? (ds_rel & ~p_ctl.rnw) : wr_rel;
  assign commit = ~mode_byte | phase_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_addr <= '0;
      phase_hi <= 1'b0;
      lo_hold  <= '0;
    end else begin
      if (mode_mux && p_ctl.ale && !s_ctl.ale) lat_addr <= s_din[ADDR_W-1:0];
      if (!mode_byte)             phase_hi <= 1'b0;
      else if (acc_rd || acc_wr)  phase_hi <= ~phase_hi;
      if (mode_byte && acc_wr && !phase_hi) lo_hold <= s_din[BYTE_W-1:0];
    end
  end

  assign cur_addr  = mode_mux ? lat_addr : s_addr;
  assign wr_ev     = acc_wr & commit;
  assign rd_ev     = acc_rd & commit;
  assign ev_data   = mode_byte ? {s_din[BYTE_W-1:0], lo_hold} : s_din;
  assign rd_active = mode_rw ? (~s_ctl.ds_n & s_ctl.rnw) : ~s_ctl.rd_n;
endmodule

// File: rtl/hip_regbank.sv
module hip_regbank #(
  parameter int DATA_W = 16,
  parameter int N_DATA = 6,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [ADDR_W-1:0] h_sel,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_word,
  input  logic              c_we,
  input  logic              c_re,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  output logic [DATA_W-1:0] c_rdata,
  output logic [N_DATA-1:0] h2c_f,
  output logic [N_DATA-1:0] c2h_f
);
  localparam logic [ADDR_W-1:0] ST_C2H = ADDR_W'(N_DATA);
  localparam logic [ADDR_W-1:0] ST_H2C = ADDR_W'(N_DATA + 1);

  logic [DATA_W-1:0] mbox [N_DATA];

  for (genvar i = 0; i < N_DATA; i++) begin : g_mbox
    logic h_hit_w, h_hit_r, c_hit_w, c_hit_r;
    assign h_hit_w = h_wr & (h_sel == ADDR_W'(i));
    assign h_hit_r = h_rd & (h_sel == ADDR_W'(i));
    assign c_hit_w = c_we & (c_addr == ADDR_W'(i));
    assign c_hit_r = c_re & (c_addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        mbox[i]  <= '0;
        h2c_f[i] <= 1'b0;
        c2h_f[i] <= 1'b0;
      end else begin
        if (h_hit_w)      mbox[i] <= h_wdata;
        else if (c_hit_w) mbox[i] <= c_wdata;
        h2c_f[i] <= h_hit_w | (h2c_f[i] & ~c_hit_r);
        c2h_f[i] <= c_hit_w | (c2h_f[i] & ~h_hit_r);
      end
    end
  end

  logic [DATA_W-1:0] c_word;

  always_comb begin
    h_word = '0;
    if (h_sel < ST_C2H)       h_word = mbox[h_sel];
    else if (h_sel == ST_C2H) h_word = DATA_W'(c2h_f);
    else if (h_sel == ST_H2C) h_word = DATA_W'(h2c_f);
    c_word = '0;
    if (c_addr < ST_C2H)       c_word = mbox[c_addr];
    else if (c_addr == ST_C2H) c_word = DATA_W'(c2h_f);
    else if (c_addr == ST_H2C) c_word = DATA_W'(h2c_f);
  end

  always_ff @(posedge clk) begin
    if (rst)       c_rdata <= '0;
    else if (c_re) c_rdata <= c_word;
  end
endmodule

// File: rtl/hip_port.sv
module hip_port
  import hip_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int N_DATA = DEF_N_DATA,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int SYNC   = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_byte,
  input  logic              mode_mux,
  input  logic              mode_rw,
  input  logic              h_ale,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_rd_n,
  input  logic              h_wr_n,
  input  logic              h_rnw,
  input  logic              h_ds_n,
  input  logic [DATA_W-1:0] h_din,
  output logic [DATA_W-1:0] h_dout,
  output logic              h_doe,
  input  logic              c_we,
  input  logic              c_re,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  output logic [DATA_W-1:0] c_rdata,
  output logic [N_DATA-1:0] h2c_flags,
  output logic [N_DATA-1:0] c2h_flags
);
  localparam int BYTE_W = DATA_W / 2;

  hctl_t             ctl_raw;
  logic              host_wr_ev, host_rd_ev, phase_hi, rd_active;
  logic [ADDR_W-1:0] host_ev_addr;
  logic [DATA_W-1:0] host_ev_data, h_word;

  assign ctl_raw = '{rd_n: h_rd_n, wr_n: h_wr_n, rnw: h_rnw, ds_n: h_ds_n, ale: h_ale};

  hip_host_fe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC(SYNC)) u_fe (
    .clk(clk), .rst(rst), .mode_byte(mode_byte), .mode_mux(mode_mux), .mode_rw(mode_rw),
    .ctl_raw(ctl_raw), .addr_raw(h_addr), .din_raw(h_din),
    .wr_ev(host_wr_ev), .rd_ev(host_rd_ev), .cur_addr(host_ev_addr),
    .ev_data(host_ev_data), .phase_hi(phase_hi), .rd_active(rd_active));

  hip_regbank #(.DATA_W(DATA_W), .N_DATA(N_DATA), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst),
    .h_wr(host_wr_ev), .h_rd(host_rd_ev), .h_sel(host_ev_addr), .h_wdata(host_ev_data),
    .h_word(h_word),
    .c_we(c_we), .c_re(c_re), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .h2c_f(h2c_flags), .c2h_f(c2h_flags));

  always_ff @(posedge clk) begin
    if (rst) begin
      h_dout <= '0;
      h_doe  <= 1'b0;
    end else begin
      h_doe <= rd_active;
      if (!mode_byte)    h_dout <= h_word;
      else if (phase_hi) h_dout <= DATA_W'(h_word[DATA_W-1:BYTE_W]);
      else               h_dout <= DATA_W'(h_word[BYTE_W-1:0]);
    end
  end
endmodule

// File: rtl/hip_port_chk.sv
module hip_port_chk #(
  parameter int N_DATA = 6,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr_ev,
  input logic              host_rd_ev,
  input logic [ADDR_W-1:0] host_ev_addr,
  input logic              c_we,
  input logic              c_re,
  input logic [ADDR_W-1:0] c_addr,
  input logic [N_DATA-1:0] h2c_flags,
  input logic [N_DATA-1:0] c2h_flags,
  input logic              h_doe
);
  localparam logic [ADDR_W-1:0] NMB = ADDR_W'(N_DATA);

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (h2c_flags == '0 && c2h_flags == '0 && !h_doe)); // R1
  AST_HOST_WR_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (host_wr_ev && host_ev_addr < NMB) |=> h2c_flags[$past(host_ev_addr)]); // R2
  AST_CORE_WR_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (c_we && c_addr < NMB) |=> c2h_flags[$past(c_addr)]); // R3
  AST_H2C_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    (!host_wr_ev && !c_re) |=> $stable(h2c_flags)); // R9
  AST_C2H_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    (!c_we && !host_rd_ev) |=> $stable(c2h_flags)); // R7
endmodule

bind hip_port hip_port_chk #(.N_DATA(N_DATA), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .host_wr_ev(host_wr_ev), .host_rd_ev(host_rd_ev),
  .host_ev_addr(host_ev_addr), .c_we(c_we), .c_re(c_re), .c_addr(c_addr),
  .h2c_flags(h2c_flags), .c2h_flags(c2h_flags), .h_doe(h_doe));

// File: tb/hip_port_bench.sv
`timescale 1ns/1ps
module hip_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_byte = 1'b0, mode_mux = 1'b0, mode_rw = 1'b0;
  logic        h_ale = 1'b0, h_rd_n = 1'b1, h_wr_n = 1'b1, h_rnw = 1'b1, h_ds_n = 1'b1;
  logic [2:0]  h_addr = '0, c_addr = '0;
  logic [15:0] h_din = '0, c_wdata = '0;
  logic        c_we = 1'b0, c_re = 1'b0;
  logic [15:0] h_dout, c_rdata;
  logic        h_doe;
  logic [5:0]  h2c_flags, c2h_flags;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] obs_val;
  event        obs_ev;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  hip_port u_hip_port (
    .clk(clk), .rst(rst), .mode_byte(mode_byte), .mode_mux(mode_mux), .mode_rw(mode_rw),
    .h_ale(h_ale), .h_addr(h_addr), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_rnw(h_rnw),
    .h_ds_n(h_ds_n), .h_din(h_din), .h_dout(h_dout), .h_doe(h_doe),
    .c_we(c_we), .c_re(c_re), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .h2c_flags(h2c_flags), .c2h_flags(c2h_flags));

  // monitor: pops expected items and compares against observed results
  initial begin
    forever begin
      @(obs_ev);
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard underflow: got %h expected nothing", obs_val);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (obs_val !== e) begin
          errors++;
          $display("FAIL %s: got %h expected %h", t, obs_val, e);
        end
      end
    end
  end

  task automatic check(input string t, input logic [15:0] got, input logic [15:0] e);
    exp_q.push_back(e);
    tag_q.push_back(t);
    obs_val = got;
    -> obs_ev;
    #0.5;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic assert_strobe(input bit rd);
    if (mode_rw) begin h_rnw = rd; @(negedge clk); h_ds_n = 1'b0; end
    else if (rd) h_rd_n = 1'b0;
    else         h_wr_n = 1'b0;
  endtask

  task automatic release_strobe();
    h_rd_n = 1'b1; h_wr_n = 1'b1; h_ds_n = 1'b1;
  endtask

  task automatic host_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); h_addr = a; h_din = d;
    wait_n(2);
    assert_strobe(1'b0);
    wait_n(4);
    release_strobe();
    wait_n(6);
    h_rnw = 1'b1;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [15:0] d, output logic oe);
    @(negedge clk); h_addr = a;
    wait_n(2);
    assert_strobe(1'b1);
    wait_n(5);
    d = h_dout; oe = h_doe;
    release_strobe();
    wait_n(6);
  endtask

  task automatic core_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); c_addr = a; c_wdata = d; c_we = 1'b1;
    @(negedge clk); c_we = 1'b0;
  endtask

  task automatic core_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); c_addr = a; c_re = 1'b1;
    @(negedge clk); c_re = 1'b0; d = c_rdata;
  endtask

  task automatic finish_run();
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    logic oe;
    wait_n(4);
    // R1 reset state
    check("R1 h_dout", h_dout, 16'h0);
    check("R1 flags", {4'h0, h2c_flags, c2h_flags}, 16'h0);
    check("R1 oe/c_rdata", {15'h0, h_doe} | c_rdata, 16'h0);
    rst = 1'b0;
    wait_n(2);

    // R2 host write, core read
    host_write(3'd2, 16'hA5C3);
    check("R2 h2c set", 16'(h2c_flags), 16'h0004);
    core_read(3'd2, v);
    check("R2 core data", v, 16'hA5C3);
    check("R2 h2c clear", 16'(h2c_flags), 16'h0000);

    // R3 core write, host read; R10 output enable
    core_write(3'd4, 16'h1234);
    check("R3 c2h set", 16'(c2h_flags), 16'h0010);
    host_read(3'd4, v, oe);
    check("R3 host data", v, 16'h1234);
    check("R10 oe during read", 16'(oe), 16'h1);
    check("R10 oe after read", 16'(h_doe), 16'h0);
    check("R3 c2h clear", 16'(c2h_flags), 16'h0000);

    // R8 status words, read-only to host
    core_write(3'd0, 16'h0F0F);
    host_read(3'd6, v, oe);
    check("R8 status c2h", v, 16'h0001);
    host_write(3'd5, 16'h7777);
    host_read(3'd7, v, oe);
    check("R8 status h2c", v, 16'h0020);
    host_write(3'd7, 16'hFFFF);
    host_read(3'd7, v, oe);
    check("R8 status write ignored", v, 16'h0020);
    check("R8 flags after status write", {4'h0, h2c_flags, c2h_flags}, {4'h0, 6'h20, 6'h01});
    core_read(3'd5, v);
    check("R2 core data reg5", v, 16'h7777);
    host_read(3'd0, v, oe);
    check("R3 host data reg0", v, 16'h0F0F);

    // R9 no effect until strobe released
    @(negedge clk); h_addr = 3'd1; h_din = 16'h5A5A;
    wait_n(2); h_wr_n = 1'b0;
    wait_n(8);
    check("R9 flag while held", 16'(h2c_flags), 16'h0000);
    core_read(3'd1, v);
    check("R9 data while held", v, 16'h0000);
    h_wr_n = 1'b1;
    wait_n(6);
    check("R9 flag after release", 16'(h2c_flags), 16'h0002);
    core_read(3'd1, v);
    check("R9 data after release", v, 16'h5A5A);

    // R4 multiplexed address
    mode_mux = 1'b1;
    @(negedge clk); h_addr = 3'd0; h_din = 16'h0003; h_ale = 1'b1;
    wait_n(3); h_ale = 1'b0;
    wait_n(4);
    host_write(3'd0, 16'hBEEF);
    core_read(3'd3, v);
    check("R4 mux write lands at latched addr", v, 16'hBEEF);
    core_read(3'd0, v);
    check("R4 h_addr ignored", v, 16'h0F0F);
    host_read(3'd0, v, oe);
    check("R4 mux read latched addr", v, 16'hBEEF);
    mode_mux = 1'b0;
    wait_n(2);

    // R5 direction + data strobe
    mode_rw = 1'b1;
    host_write(3'd1, 16'h1357);
    core_read(3'd1, v);
    check("R5 rw write", v, 16'h1357);
    core_write(3'd1, 16'h4321);
    host_read(3'd1, v, oe);
    check("R5 rw read", v, 16'h4321);
    check("R5 c2h clear", 16'(c2h_flags), 16'h0000);
    mode_rw = 1'b0;
    wait_n(2);

    // R6 byte writes commit on high byte
    mode_byte = 1'b1;
    wait_n(2);
    host_write(3'd0, 16'h00AB);
    check("R6 flag after low", 16'(h2c_flags), 16'h0000);
    core_read(3'd0, v);
    check("R6 data after low", v, 16'h0F0F);
    host_write(3'd0, 16'h00CD);
    check("R6 flag after high", 16'(h2c_flags), 16'h0001);
    core_read(3'd0, v);
    check("R6 data after high", v, 16'hCDAB);

    // R7 byte reads, low then high
    core_write(3'd2, 16'h9A8B);
    host_read(3'd2, v, oe);
    check("R7 low byte", v, 16'h008B);
    check("R7 flag after low", 16'(c2h_flags), 16'h0004);
    host_read(3'd2, v, oe);
    check("R7 high byte", v, 16'h009A);
    check("R7 flag after high", 16'(c2h_flags), 16'h0000);

    wait_n(4);
    done = 1'b1;
    finish_run();
  end
endmodule